// File: doc/BRIEF.md
# Peripheral Clock-Enable Generator with Two Cascaded Dividers

The block turns one of three free-running tick streams, all synchronous to a common reference clock, into one or two clock-enable strobes for a peripheral. A 32-bit control register picks the tick source and holds two 6-bit divisors. The first divider counts source ticks. The second divider counts the wraps of the first. The total division ratio is therefore the product of the two effective divisors. A per-output gate bit lets each strobe through or holds it low.

Two build-time variants extend the basic path. With the external-mux variant, a control bit replaces the divided tick by an external tick input, ahead of the gates. With the fabric-gate variant, output 0 is gated by bit 0 of a second register eight bytes above the control register. In that register a 1 disables the output, and control bit 0 no longer affects output 0.

Divisor and source changes are held back until the divided tick wraps, so an update never cuts an output period short.

Top module: `periph_tick_gen`

## Requirements
- R1: After reset the control register (byte offset 0) reads 0x00100100: both divisors 1, source code 0, gate bits 0. All outputs stay low. In the fabric-gate variant the gate register (byte offset 8) reads 1.
- R2: The source code in control bits [5:4] selects the tick stream. Codes 0 and 1 select source C (`src_tick[2]`), code 2 selects source A (`src_tick[0]`) and code 3 selects source B (`src_tick[1]`).
- R3: The first divisor sits in control bits [13:8] and the second in bits [25:20]. The second stage counts wraps of the first, so an output strobe comes once every eff1*eff2 ticks of the selected source.
- R4: A divisor field of 0 acts as divide-by-one.
- R5: Output i (i = 0 or 1) passes strobes only while control bit i is 1. While the bit is 0 the output stays low. Both outputs share the same divided tick.
- R6: In the external-mux variant, control bit 6 set to 1 routes `ext_tick` to the gates in place of the divided tick. An external tick in cycle t gives an output strobe in cycle t+1.
- R7: In the fabric-gate variant, bit 0 of the register at byte offset 8 set to 1 holds output 0 low, and 0 lets it pass. Control bit 0 has no effect on that output.
- R8: A new divisor or source value takes effect only when the divided tick wraps. The period in progress when the register is written completes with the old setting.
- R9: Reading the control register returns the stored fields. Unimplemented bits read 0, so writing all ones reads back 0x03F03F73 in the default build and 0x03F03F31 in a one-output build without the external mux.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Source tick streams: bit 0 = A, bit 1 = B, bit 2 = C |
| ext_tick | input | 1 | External tick, used when the external mux is selected |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register byte offset: 0 = control, 8 = gate |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| clk_en_out | output | NUM_OUTS (2) | Gated clock-enable strobes |

## Verification
The bench sweeps divisor pairs, including zero in either field and the 63 maximum, and measures the output period against the product of the effective divisors. A design that treated zero as divide-by-zero or 64, or that fed stage two from the source instead of from stage one, shows a wrong period there. Each source code is run against tick streams of different rates, which exposes a swapped mux table. The bench writes a short divisor in the cycle right after a strobe and checks that the next strobe still arrives after the old period, so a design that reloads mid-period fails.

External bypass latency, gate independence and the inverted polarity of the fabric gate are each checked at the outputs. Readback of an all-ones write is also checked.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  localparam int REG_W       = 32;
  localparam int SEL_LSB     = 4;
  localparam int SEL_W       = 2;
  localparam int EXT_BIT     = 6;
  localparam int D1_LSB      = 8;
  localparam int D2_LSB      = 20;
  localparam int CTRL_OFFSET = 0;
  localparam int GATE_OFFSET = 8;

  // Bits of the control register that hold state for a given build.
  function automatic logic [REG_W-1:0] ctrl_mask(int num_outs, bit has_ext, int div_w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < num_outs; i++) m[i] = 1'b1;
    for (int i = 0; i < SEL_W; i++) m[SEL_LSB + i] = 1'b1;
    if (has_ext) m[EXT_BIT] = 1'b1;
    for (int b = 0; b < div_w; b++) begin
      m[D1_LSB + b] = 1'b1;
      m[D2_LSB + b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_reset();
    logic [REG_W-1:0] v;
    v = '0;
    v[D1_LSB] = 1'b1;
    v[D2_LSB] = 1'b1;
    return v;
  endfunction

  // Effective divide ratio: zero behaves as one.
  function automatic int unsigned eff_div(int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // Source code to tick-stream index (0 = A, 1 = B, 2 = C).
  function automatic int unsigned src_index(logic [SEL_W-1:0] code);
    case (code)
      2'd2:    return 0;
      2'd3:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int stage_lsb(int k);
    return (k == 0) ? D1_LSB : D2_LSB;
  endfunction

endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
  import ptg_pkg::*;
#(
  parameter int NUM_OUTS    = 2,
  parameter bit HAS_EXT_MUX = 1'b1,
  parameter bit FABRIC_GATE = 1'b0,
  parameter int DIV_W       = 6,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  ctrl_o,
  output logic              gate_off_o
);

  localparam logic [REG_W-1:0] MASK  = ctrl_mask(NUM_OUTS, HAS_EXT_MUX, DIV_W);
  localparam logic [REG_W-1:0] RSTV  = ctrl_reset();
  localparam logic              GRST = FABRIC_GATE;

  logic [REG_W-1:0] ctrl_q;
  logic             gate_q;
  logic             hit_ctrl, hit_gate;

  assign hit_ctrl = (addr == ADDR_W'(CTRL_OFFSET));
  assign hit_gate = (addr == ADDR_W'(GATE_OFFSET)) && FABRIC_GATE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RSTV;
      gate_q <= GRST;
    end else if (we) begin
      if (hit_ctrl) ctrl_q <= wdata & MASK;
      if (hit_gate) gate_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)      rdata = ctrl_q;
    else if (hit_gate) rdata = {{(REG_W-1){1'b0}}, gate_q};
  end

  assign ctrl_o     = ctrl_q;
  assign gate_off_o = gate_q;

  // R9: stored bits never leave the implemented field set
  a_r9_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~MASK) == '0);

endmodule

// File: rtl/ptg_src_mux.sv
module ptg_src_mux
  import ptg_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_SRC-1:0] grant,
  output logic               tick_o
);

  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_index(sel) == i) grant[i] = 1'b1;
  end

  assign tick_o = |(grant & src_tick);

endmodule

// File: rtl/ptg_div_stage.sv
module ptg_div_stage
  import ptg_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit  = DIV_W'(eff_div(int'(div_i)) - 1);
  assign tick_o = tick_i && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R3: count never passes the wrap point of the divisor it is using
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

endmodule

// File: rtl/periph_tick_gen.sv
module periph_tick_gen
  import ptg_pkg::*;
#(
  parameter int NUM_OUTS    = 2,
  parameter bit HAS_EXT_MUX = 1'b1,
  parameter bit FABRIC_GATE = 1'b0,
  parameter int DIV_W       = 6,
  parameter int ADDR_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          src_tick,
  input  logic                ext_tick,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_OUTS-1:0] clk_en_out
);

  localparam int NUM_SRC    = 3;
  localparam int NUM_STAGES = 2;

  logic [REG_W-1:0]  ctrl;
  logic              gate_off;
  logic              ext_sel;
  logic [NUM_OUTS-1:0] gate_en;

  ptg_regs #(
    .NUM_OUTS(NUM_OUTS), .HAS_EXT_MUX(HAS_EXT_MUX), .FABRIC_GATE(FABRIC_GATE),
    .DIV_W(DIV_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl_o(ctrl), .gate_off_o(gate_off)
  );

  // Active configuration, reloaded only at a divided-tick wrap.
  logic [SEL_W-1:0]                  act_sel_q;
  logic [NUM_STAGES-1:0][DIV_W-1:0]  act_div_q;
  logic [NUM_STAGES:0]               stage_tick;
  logic [NUM_SRC-1:0]                src_grant;
  logic                              div_tick;
  logic                              pre_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel_q <= '0;
      for (int k = 0; k < NUM_STAGES; k++) act_div_q[k] <= DIV_W'(1);
    end else if (div_tick) begin
      act_sel_q <= ctrl[SEL_LSB +: SEL_W];
      for (int k = 0; k < NUM_STAGES; k++)
        act_div_q[k] <= ctrl[stage_lsb(k) +: DIV_W];
    end
  end

  ptg_src_mux #(.NUM_SRC(NUM_SRC)) u_src_mux (
    .src_tick(src_tick), .sel(act_sel_q), .grant(src_grant), .tick_o(stage_tick[0])
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    ptg_div_stage #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_i(stage_tick[k]),
      .div_i(act_div_q[k]), .tick_o(stage_tick[k+1])
    );
  end

  assign div_tick = stage_tick[NUM_STAGES];
  assign ext_sel  = HAS_EXT_MUX && ctrl[EXT_BIT];
  assign pre_gate = ext_sel ? ext_tick : div_tick;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
    if (i == 0) begin : g_first
      assign gate_en[i] = FABRIC_GATE ? ~gate_off : ctrl[i];
    end else begin : g_rest
      assign gate_en[i] = ctrl[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_en_out[i] <= 1'b0;
      else        clk_en_out[i] <= gate_en[i] & pre_gate;
    end

    // R5 / R7: a closed gate keeps its output low in the next cycle
    a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en[i] |=> !clk_en_out[i]);
  end

  // R2: exactly one source stream is granted at a time
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_grant) && (src_grant != '0));

  // R3: a divided tick is always also a wrap of the first stage
  a_r3_chain: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> stage_tick[1]);

  // R8: active divisors and source change only right after a wrap
  a_r8_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_sel_q, act_div_q}) |-> $past(div_tick));

  // R6: selected external tick reaches an open output one cycle later
  a_r6_ext_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && gate_en[0] && ext_tick) |=> clk_en_out[0]);

endmodule

// File: tb/periph_tick_gen_bench.sv
module periph_tick_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = 3'b000;
  logic        ext_tick = 1'b0;
  logic        we = 1'b0, fwe = 1'b0;
  logic [3:0]  addr = 4'd0, faddr = 4'd0;
  logic [31:0] wdata = '0, fwdata = '0;
  logic [31:0] rdata, frdata;
  logic [1:0]  out;
  logic [0:0]  fout;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;

  always #2 clk = ~clk;

  periph_tick_gen u_periph_tick_gen (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ext_tick(ext_tick),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .clk_en_out(out)
  );

  periph_tick_gen #(.NUM_OUTS(1), .HAS_EXT_MUX(1'b0), .FABRIC_GATE(1'b1)) u_periph_tick_gen_fab (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ext_tick(1'b0),
    .reg_we(fwe), .reg_addr(faddr), .reg_wdata(fwdata), .reg_rdata(frdata),
    .clk_en_out(fout)
  );

  // Source streams: A every cycle, B every second, C every fourth.
  initial begin
    forever begin
      @(negedge clk);
      phase = phase + 1;
      src_tick = {(phase % 4) == 0, (phase % 2) == 0, 1'b1};
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(int sel, int d1, int d2, int gates, int ext);
    return 32'(gates) | (32'(sel) << 4) | (32'(ext) << 6) | (32'(d1) << 8) | (32'(d2) << 20);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 4'd0;
  endtask

  task automatic fwr(input logic [3:0] a, input logic [31:0] d);
    faddr = a; fwdata = d; fwe = 1'b1;
    @(negedge clk);
    fwe = 1'b0; faddr = 4'd0;
  endtask

  task automatic next_pulse(input int idx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out[idx] && n < 20000);
    if (n >= 20000) check(1'b0, "timeout waiting for strobe", n, 0);
  endtask

  task automatic period(input int idx, output int per);
    int d;
    next_pulse(idx, d);
    next_pulse(idx, d);
    next_pulse(idx, per);
  endtask

  task automatic count(input int n, output int c0, output int c1, output int cf);
    c0 = 0; c1 = 0; cf = 0;
    repeat (n) begin
      @(negedge clk);
      c0 += int'(out[0]); c1 += int'(out[1]); cf += int'(fout[0]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p, c0, c1, cf, g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    addr = 4'd0; faddr = 4'd8;
    @(negedge clk);
    check(rdata == 32'h0010_0100, "R1 ctrl reset value", rdata, 32'h0010_0100);
    check(frdata == 32'd1, "R1 gate reg reset value", frdata, 1);
    count(16, c0, c1, cf);
    check(c0 == 0 && c1 == 0 && cf == 0, "R1 outputs low after reset", c0 + c1 + cf, 0);

    // R2 source select, divisor 3 x 1
    for (int s = 0; s < 4; s++) begin
      int exp;
      exp = 3 * ((s == 2) ? 1 : (s == 3) ? 2 : 4);
      wr(4'd0, cfg(s, 3, 1, 3, 0));
      period(0, p);
      check(p == exp, $sformatf("R2 source code %0d period", s), p, exp);
    end

    // R3 / R4 divisor sweep on source A
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 5; b++) begin
        int exp;
        exp = ((a == 0) ? 1 : a) * ((b == 0) ? 1 : b);
        wr(4'd0, cfg(2, a, b, 3, 0));
        period(0, p);
        check(p == exp, $sformatf("R3 R4 divisors %0d,%0d period", a, b), p, exp);
      end
    end
    wr(4'd0, cfg(2, 63, 2, 3, 0));
    period(1, p);
    check(p == 126, "R3 divisors 63,2 on output 1", p, 126);
    wr(4'd0, cfg(2, 0, 63, 3, 0));
    period(0, p);
    check(p == 63, "R4 zero first divisor with 63", p, 63);
    wr(4'd0, cfg(2, 63, 63, 3, 0));
    period(0, p);
    check(p == 3969, "R3 divisors 63,63 period", p, 3969);

    // R8 update only at a wrap: 16-cycle period, then switch to 1
    wr(4'd0, cfg(2, 4, 4, 1, 0));
    period(0, p);
    check(p == 16, "R8 setup period", p, 16);
    wr(4'd0, cfg(2, 1, 1, 1, 0));
    next_pulse(0, g);
    check(1 + g == 16, "R8 period in progress keeps old divisor", 1 + g, 16);
    next_pulse(0, g);
    check(g == 1, "R8 new divisor after wrap", g, 1);

    // R5 gates, divided period 1
    wr(4'd0, cfg(2, 1, 1, 1, 0));
    repeat (2) @(negedge clk);
    count(20, c0, c1, cf);
    check(c0 == 20, "R5 output 0 open", c0, 20);
    check(c1 == 0, "R5 output 1 closed", c1, 0);
    wr(4'd0, cfg(2, 1, 1, 2, 0));
    repeat (2) @(negedge clk);
    count(20, c0, c1, cf);
    check(c0 == 0, "R5 output 0 closed", c0, 0);
    check(c1 == 20, "R5 output 1 open", c1, 20);

    // R6 external bypass, only output 0 open
    wr(4'd0, cfg(2, 1, 1, 1, 1));
    repeat (2) @(negedge clk);
    count(10, c0, c1, cf);
    check(c0 == 0 && c1 == 0, "R6 divided tick blocked while bypassed", c0 + c1, 0);
    ext_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0;
    check(out[0] == 1'b1, "R6 strobe one cycle after external tick", out[0], 1);
    check(out[1] == 1'b0, "R6 R5 closed gate after bypass", out[1], 0);
    @(negedge clk);
    check(out[0] == 1'b0, "R6 single strobe per external tick", out[0], 0);
    c0 = 0;
    for (int k = 0; k < 32; k++) begin
      ext_tick = (k % 3) == 0;
      @(negedge clk);
      c0 += int'(out[0]);
    end
    ext_tick = 1'b0;
    repeat (2) begin @(negedge clk); c0 += int'(out[0]); end
    check(c0 == 11, "R6 external burst count", c0, 11);
    wr(4'd0, cfg(2, 1, 1, 3, 0));
    repeat (2) @(negedge clk);

    // R7 fabric gate polarity (source C, period 4)
    fwr(4'd0, cfg(0, 1, 1, 0, 0));
    count(40, c0, c1, cf);
    check(cf == 0, "R7 gate bit 1 disables", cf, 0);
    fwr(4'd8, 32'd0);
    repeat (2) @(negedge clk);
    count(40, c0, c1, cf);
    check(cf == 10, "R7 gate bit 0 enables with ctrl bit 0 clear", cf, 10);
    fwr(4'd0, cfg(0, 1, 1, 1, 0));
    repeat (2) @(negedge clk);
    count(40, c0, c1, cf);
    check(cf == 10, "R7 ctrl bit 0 no effect", cf, 10);
    fwr(4'd8, 32'd1);
    repeat (2) @(negedge clk);
    count(40, c0, c1, cf);
    check(cf == 0, "R7 gate bit set holds low", cf, 0);
    faddr = 4'd8;
    @(negedge clk);
    check(frdata == 32'd1, "R7 gate reg readback", frdata, 1);

    // R9 readback masks
    wr(4'd0, 32'hFFFF_FFFF);
    addr = 4'd0;
    @(negedge clk);
    check(rdata == 32'h03F0_3F73, "R9 ctrl all-ones readback", rdata, 32'h03F0_3F73);
    addr = 4'd8;
    @(negedge clk);
    check(rdata == 32'd0, "R9 no gate register in default build", rdata, 0);
    fwr(4'd0, 32'hFFFF_FFFF);
    faddr = 4'd0;
    @(negedge clk);
    check(frdata == 32'h03F0_3F31, "R9 one-output build readback", frdata, 32'h03F0_3F31);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule